// File: doc/BRIEF.md
# Two-Channel Broadcast Configuration Register Bank

This block holds the configuration state of a two-channel signal generator. A range of per-channel register addresses is backed by one private copy for each channel, while a few global registers exist only once. A channel-select register at address 0x00 holds one enable bit per channel. A write to a per-channel address lands in the copy of every channel whose enable bit is set, so the same setting can be broadcast to both channels in one transfer, or steered to a single channel by clearing the other enable bit. After reset both channels are enabled.

The bank sits behind a serial port controller that has already turned the serial stream into parallel register accesses. Requests arrive on a valid/ready port with a byte-enable mask, so a transfer cut short mid-register updates only the bytes that completed. Read responses leave on a second valid/ready port. Every register copy is also presented in parallel to the datapath.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is waiting and `rsp_ready` is low. A read response appears with `rsp_valid` on the cycle after its request was taken, and `rsp_data` stays frozen until `rsp_ready` is seen high. Writes produce no response.

Top module: `bcast_regbank`

## Requirements
- R1: After reset both channel enable bits read as 1, every register copy and every global register is zero, and `rsp_valid` is low.
- R2: With both channels enabled, one write to a per-channel address (0x03 to 0x18) updates both channels' copies at that address in the same cycle.
- R3: A write to a per-channel address changes only the copies of channels whose enable bit is set; other channels' copies keep their values.
- R4: With no channel enabled, writes to per-channel addresses change nothing, while writes to global addresses still take effect.
- R5: Byte lane i of a register (bits 8i+7 to 8i) is written only when `req_be[i]` is 1; lanes with a 0 keep their previous value.
- R6: The channel-select register is address 0x00; bit 6 enables channel 0 and bit 7 enables channel 1, written through byte lane 0; a read returns the enables in bits 7:6 and zeros elsewhere.
- R7: A read of a per-channel address returns the copy of the lowest-numbered enabled channel, and zero when no channel is enabled.
- R8: Addresses 0x01 and 0x02 are global registers with a single copy that read back what was written; addresses above 0x18 read as zero and ignore writes.
- R9: A read response is valid on the cycle after the request is taken; while `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane write enables |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Read data |
| ch_en | output | 2 | Current channel enable bits, bit 0 is channel 0 |
| ch_regs | output | 1408 | All per-channel copies, channel c register r at bits ((c*22+r)*32) upward |
| glb_regs | output | 64 | Global registers 0x01 and 0x02, in address order |

## Verification
The hardest state to reach from the ports is two channels holding different values at the same per-channel address while both are enabled, since that is the only case where the lowest-channel readback rule is visible. Reaching it needs a chain: disable one channel, write, swap the mask, write again, re-enable both, then read. Directed sequences build this chain explicitly, and the random phase biases a large share of its writes toward the channel-select register so masks change often and the copies drift apart before shared reads and the no-channel case are hit.

// File: rtl/bbank_pkg.sv
package bbank_pkg;
  typedef enum logic [1:0] {
    AC_CSEL   = 2'd0,
    AC_GLOB   = 2'd1,
    AC_SHARED = 2'd2,
    AC_NONE   = 2'd3
  } addr_class_e;
endpackage

// File: rtl/bbank_decode.sv
module bbank_decode
  import bbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 2,
  parameter int GLB_LO = 1,
  parameter int GLB_HI = 2,
  parameter int SH_LO  = 3,
  parameter int SH_HI  = 24,
  parameter int GIDX_W = 1,
  parameter int SIDX_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_fire,
  input  logic [NUM_CH-1:0] ch_en,
  output addr_class_e       cls,
  output logic [GIDX_W-1:0] glb_idx,
  output logic [SIDX_W-1:0] sh_idx,
  output logic              csel_we,
  output logic              glb_we,
  output logic [NUM_CH-1:0] ch_we
);
  always_comb begin
    if (addr == '0)                                          cls = AC_CSEL;
    else if (addr >= ADDR_W'(GLB_LO) && addr <= ADDR_W'(GLB_HI)) cls = AC_GLOB;
    else if (addr >= ADDR_W'(SH_LO) && addr <= ADDR_W'(SH_HI))   cls = AC_SHARED;
    else                                                     cls = AC_NONE;
  end

  assign glb_idx = GIDX_W'(addr - ADDR_W'(GLB_LO));
  assign sh_idx  = SIDX_W'(addr - ADDR_W'(SH_LO));
  assign csel_we = wr_fire && (cls == AC_CSEL);
  assign glb_we  = wr_fire && (cls == AC_GLOB);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_steer
    assign ch_we[c] = wr_fire && (cls == AC_SHARED) && ch_en[c];
  end
endmodule

// File: rtl/bbank_regfile.sv
module bbank_regfile #(
  parameter int NREG   = 22,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [BE_W-1:0]        be,
  output logic [NREG*DATA_W-1:0] regs_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit;
    assign hit = we && (idx == IDX_W'(r));
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
        if (!rst_n)              lane_q <= '0;
        else if (hit && be[b])   lane_q <= wdata[b*8 +: 8];
      end
      assign regs_o[r*DATA_W + b*8 +: 8] = lane_q;
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(idx) < NREG)); // R3
endmodule

// File: rtl/bbank_rdmux.sv
module bbank_rdmux
  import bbank_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int DATA_W   = 32,
  parameter int NSH      = 22,
  parameter int NGLB     = 2,
  parameter int GIDX_W   = 1,
  parameter int SIDX_W   = 5,
  parameter int CSEL_LSB = 6
) (
  input  addr_class_e                   cls,
  input  logic [GIDX_W-1:0]             glb_idx,
  input  logic [SIDX_W-1:0]             sh_idx,
  input  logic [NUM_CH-1:0]             ch_en,
  input  logic [NUM_CH*NSH*DATA_W-1:0]  ch_regs,
  input  logic [NGLB*DATA_W-1:0]        glb_regs,
  output logic [DATA_W-1:0]             rd_data
);
  always_comb begin
    rd_data = '0;
    unique case (cls)
      AC_CSEL: rd_data[CSEL_LSB +: NUM_CH] = ch_en;
      AC_GLOB: begin
        for (int g = 0; g < NGLB; g++)
          if (g == int'(glb_idx)) rd_data = glb_regs[g*DATA_W +: DATA_W];
      end
      AC_SHARED: begin
        // walk from the highest channel down so the lowest enabled one wins
        for (int c = NUM_CH - 1; c >= 0; c--) begin
          if (ch_en[c]) begin
            for (int r = 0; r < NSH; r++)
              if (r == int'(sh_idx)) rd_data = ch_regs[(c*NSH + r)*DATA_W +: DATA_W];
          end
        end
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/bcast_regbank.sv
module bcast_regbank
  import bbank_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int GLB_LO   = 1,
  parameter int GLB_HI   = 2,
  parameter int SH_LO    = 3,
  parameter int SH_HI    = 24,
  parameter int CSEL_LSB = 6,
  localparam int BE_W    = DATA_W / 8,
  localparam int NSH     = SH_HI - SH_LO + 1,
  localparam int NGLB    = GLB_HI - GLB_LO + 1,
  localparam int SIDX_W  = (NSH > 1) ? $clog2(NSH) : 1,
  localparam int GIDX_W  = (NGLB > 1) ? $clog2(NGLB) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic [BE_W-1:0]               req_be,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [DATA_W-1:0]             rsp_data,
  output logic [NUM_CH-1:0]             ch_en,
  output logic [NUM_CH*NSH*DATA_W-1:0]  ch_regs,
  output logic [NGLB*DATA_W-1:0]        glb_regs
);
  localparam int CSEL_LANE = CSEL_LSB / 8;

  logic              fire, wr_fire, rd_fire;
  addr_class_e       cls;
  logic [GIDX_W-1:0] glb_idx;
  logic [SIDX_W-1:0] sh_idx;
  logic              csel_we, glb_we;
  logic [NUM_CH-1:0] ch_we;
  logic [NUM_CH-1:0] en_q;
  logic [DATA_W-1:0] rd_data;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_fire   = fire && req_write;
  assign rd_fire   = fire && !req_write;
  assign ch_en     = en_q;

  bbank_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .GLB_LO(GLB_LO), .GLB_HI(GLB_HI),
    .SH_LO(SH_LO), .SH_HI(SH_HI), .GIDX_W(GIDX_W), .SIDX_W(SIDX_W)
  ) u_decode (
    .addr(req_addr), .wr_fire(wr_fire), .ch_en(en_q), .cls(cls),
    .glb_idx(glb_idx), .sh_idx(sh_idx), .csel_we(csel_we),
    .glb_we(glb_we), .ch_we(ch_we)
  );

  // channel-select register: only the enable field is stored
  always_ff @(posedge clk) begin
    if (!rst_n)                           en_q <= '1;
    else if (csel_we && req_be[CSEL_LANE]) en_q <= req_wdata[CSEL_LSB +: NUM_CH];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    bbank_regfile #(.NREG(NSH), .DATA_W(DATA_W), .IDX_W(SIDX_W)) u_copy (
      .clk(clk), .rst_n(rst_n), .we(ch_we[c]), .idx(sh_idx),
      .wdata(req_wdata), .be(req_be),
      .regs_o(ch_regs[c*NSH*DATA_W +: NSH*DATA_W])
    );
  end

  bbank_regfile #(.NREG(NGLB), .DATA_W(DATA_W), .IDX_W(GIDX_W)) u_glob (
    .clk(clk), .rst_n(rst_n), .we(glb_we), .idx(glb_idx),
    .wdata(req_wdata), .be(req_be), .regs_o(glb_regs)
  );

  bbank_rdmux #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .NSH(NSH), .NGLB(NGLB),
    .GIDX_W(GIDX_W), .SIDX_W(SIDX_W), .CSEL_LSB(CSEL_LSB)
  ) u_rdmux (
    .cls(cls), .glb_idx(glb_idx), .sh_idx(sh_idx), .ch_en(en_q),
    .ch_regs(ch_regs), .glb_regs(glb_regs), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_ready) begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_data <= rd_data;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R9
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid); // R9
  AST_MASK_STEER: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_we & ~en_q) == '0); // R3
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({csel_we, glb_we, |ch_we})); // R8
  AST_NONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && en_q == '0 && req_addr >= ADDR_W'(SH_LO) && req_addr <= ADDR_W'(SH_HI))
      |=> $stable(ch_regs)); // R4
  AST_NONE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && en_q == '0 && req_addr >= ADDR_W'(SH_LO) && req_addr <= ADDR_W'(SH_HI))
      |=> (rsp_data == '0)); // R7
  AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && req_addr == ADDR_W'(GLB_LO) && !req_be[0]) |=> $stable(glb_regs[7:0])); // R5
endmodule

// File: tb/test_bcast_regbank.sv
module test_bcast_regbank;
  localparam int NCH = 2, DW = 32, AW = 8, NSH = 22, NGLB = 2, SHLO = 3, SHHI = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [NCH-1:0] ch_en;
  logic [NCH*NSH*DW-1:0] ch_regs;
  logic [NGLB*DW-1:0] glb_regs;

  bcast_regbank i_bcast_regbank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .ch_en(ch_en), .ch_regs(ch_regs), .glb_regs(glb_regs)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] m_ch [NCH][NSH];
  logic [DW-1:0] m_glb [NGLB];
  logic [NCH-1:0] m_en;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d, logic [3:0] be);
    logic [DW-1:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    if (a == 0) r[7:6] = m_en;
    else if (a >= 1 && a <= 2) r = m_glb[a-1];
    else if (a >= SHLO && a <= SHHI) begin
      if (m_en[0]) r = m_ch[0][a-SHLO];
      else if (m_en[1]) r = m_ch[1][a-SHLO];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(string req);
    bit ok = (ch_en === m_en);
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NSH; r++)
        if (ch_regs[(c*NSH+r)*DW +: DW] !== m_ch[c][r]) ok = 0;
    for (int g = 0; g < NGLB; g++) if (glb_regs[g*DW +: DW] !== m_glb[g]) ok = 0;
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: outputs differ from model (ch_en actual %b expected %b)", req, ch_en, m_en);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic [3:0] be);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0;
    if (a == 0) begin if (be[0]) m_en = d[7:6]; end
    else if (a >= 1 && a <= 2) m_glb[a-1] = merge(m_glb[a-1], d, be);
    else if (a >= SHLO && a <= SHHI)
      for (int c = 0; c < NCH; c++) if (m_en[c]) m_ch[c][a-SHLO] = merge(m_ch[c][a-SHLO], d, be);
  endtask

  task automatic rd(logic [AW-1:0] a, string req);
    logic [DW-1:0] e = exp_read(a);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk({req, " rsp_valid"}, DW'(rsp_valid), 1);
    chk(req, rsp_data, e);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'hC0FFEE));
    m_en = 2'b11;
    for (int c = 0; c < NCH; c++) for (int r = 0; r < NSH; r++) m_ch[c][r] = '0;
    for (int g = 0; g < NGLB; g++) m_glb[g] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_outputs("R1");
    chk("R1 rsp_valid", DW'(rsp_valid), 0);
    // R2 broadcast
    wr(8'h05, 32'hA5A5_1234, 4'hF);
    chk("R2 ch0", ch_regs[(0*NSH+2)*DW +: DW], 32'hA5A5_1234);
    chk("R2 ch1", ch_regs[(1*NSH+2)*DW +: DW], 32'hA5A5_1234);
    // R3 / R6 steer to channel 1 only (bit 7)
    wr(8'h00, 32'h0000_0080, 4'h1);
    rd(8'h00, "R6 csel readback");
    wr(8'h05, 32'h1111_2222, 4'hF);
    chk("R3 ch0 kept", ch_regs[(0*NSH+2)*DW +: DW], 32'hA5A5_1234);
    chk("R3 ch1 written", ch_regs[(1*NSH+2)*DW +: DW], 32'h1111_2222);
    rd(8'h05, "R7 single ch1");
    // R7 both enabled, copies differ: lowest wins
    wr(8'h00, 32'hFFFF_FFFF, 4'h1);
    rd(8'h00, "R6 all bits set");
    rd(8'h05, "R7 lowest channel");
    // R4 no channel
    wr(8'h00, 32'h0, 4'h1);
    wr(8'h05, 32'hDEAD_BEEF, 4'hF);
    wr(8'h02, 32'hCAFE_F00D, 4'hF);
    chk_outputs("R4");
    chk("R4 global", glb_regs[DW +: DW], 32'hCAFE_F00D);
    rd(8'h05, "R7 none enabled");
    // R5 byte lanes
    wr(8'h01, 32'h4433_2211, 4'b0101);
    chk("R5 lanes", glb_regs[0 +: DW], 32'h0033_0011);
    wr(8'h00, 32'h0000_0040, 4'h1);
    wr(8'h18, 32'h8877_6655, 4'b1010);
    chk_outputs("R5 shared lanes");
    // R6 csel lane disabled
    wr(8'h00, 32'h0000_0000, 4'h2);
    rd(8'h00, "R6 lane0 off");
    // R8 out of map
    wr(8'h19, 32'h1234_5678, 4'hF);
    chk_outputs("R8 ignored");
    rd(8'h19, "R8 out of map");
    rd(8'h02, "R8 global read");
    // R9 stall
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = 8'h02;
    @(negedge clk);
    req_valid = 0;
    chk("R9 valid", DW'(rsp_valid), 1);
    chk("R9 ready low", DW'(req_ready), 0);
    held = rsp_data;
    req_valid = 1; req_addr = 8'h00;
    @(negedge clk);
    chk("R9 held", rsp_data, held);
    chk("R9 held data", held, m_glb[1]);
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    chk("R9 drained", DW'(rsp_valid), 0);
    // random phase
    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 9);
      logic [AW-1:0] a;
      if (k < 2) a = 8'h00;
      else if (k < 3) a = AW'($urandom_range(1, 2));
      else if (k < 9) a = AW'($urandom_range(SHLO, SHHI));
      else a = AW'($urandom_range(SHHI + 1, 40));
      if ($urandom_range(0, 1) == 1) begin
        wr(a, $urandom, 4'($urandom));
        chk_outputs("R3 random write");
      end else
        rd(a, "R7 random read");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule